// File: doc/BRIEF.md
# Programmable Pattern-Match Logic Array

This block is a small programmable logic array that works like a content-matching memory. It keeps `NUM_PAT` stored patterns, each `PAT_W` bits wide and made of a value word and a care-mask word. Every input word is compared with all patterns at the same time, and each pattern produces one output bit. Output bit `i` always belongs to pattern `i`.

Three runtime settings control the result. The first chooses how positions are compared. In array comparison, only the stored ones take part. In plane comparison, both stored zeros and stored ones take part, and masked positions are don't-cares. The second setting picks the reduction over the significant positions: AND, OR, NAND or NOR. The third setting makes the output either combinational or registered.

A single write port can load or replace any pattern at any time. Later comparisons use the new contents.

Top module: `pla_match_array`

## Requirements
- R1: While reset is asserted, the registered output reads 0 (with `cfg_sync`=1). After reset, every pattern holds value 0 and care 0.
- R2: With `cfg_plane`=0 (array comparison), a position is significant only where value AND care is 1. A significant position matches when the input bit is 1. Extra input ones do no harm.
- R3: With `cfg_plane`=1 (plane comparison), a position is significant where care is 1, and it matches when the input bit equals the value bit. Positions with care 0 are ignored.
- R4: `cfg_func`=0 selects AND. `dout[i]` is 1 exactly when every significant position of pattern i matches.
- R5: `cfg_func`=1 selects OR. `dout[i]` is 1 when at least one significant position of pattern i matches.
- R6: `cfg_func`=2 (NAND) gives the inverse of the AND result, and `cfg_func`=3 (NOR) gives the inverse of the OR result.
- R7: A pattern with no significant position gives 1 under AND, 0 under OR, 0 under NAND and 1 under NOR.
- R8: With `cfg_sync`=0, `dout` follows `din`, the settings and the stored contents combinationally, within the same cycle.
- R9: With `cfg_sync`=1, `dout` shows the result for the inputs, settings and contents present at the previous rising clock edge. It holds that value between edges.
- R10: A write with `wr_en`=1 stores `wr_value` and `wr_care` into pattern `wr_idx` at the rising edge. The old contents stay visible until that edge. Other patterns are unchanged.
- R11: Load patterns 0..2 as 11001100, 00110011 and 00001111, all with full care, and select array comparison with AND. The inputs 11001100, 00001111, 10101010, 11000000 and 00111111 then give {dout[0],dout[1],dout[2]} = 100, 001, 000, 000 and 011. With plane comparison, input 00111111 gives 000. A plane pattern with value 0011xxxx and care 11110000 matches whenever `din[7:4]`=0011.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_plane | input | 1 | 1 = plane comparison, 0 = array comparison |
| cfg_func | input | 2 | Reduction: 0 AND, 1 OR, 2 NAND, 3 NOR |
| cfg_sync | input | 1 | 1 = registered output, 0 = combinational output |
| wr_en | input | 1 | Pattern write enable |
| wr_idx | input | IDX_W | Index of the pattern to write |
| wr_value | input | PAT_W | Value word to store |
| wr_care | input | PAT_W | Care mask to store (1 = significant) |
| din | input | PAT_W | Input word compared against all patterns |
| dout | output | NUM_PAT | One result bit per pattern, bit i for pattern i |

## Verification
The timing of each result depends on the mode:
- **Combinational mode:** results settle within the cycle. The bench samples them 1 ns after it changes `din` or the settings, and no clock edge is needed.
- **Registered mode:** a result appears one rising edge after its inputs are present. The bench drives on the falling edge, checks 1 ns later that the previous value still holds, and checks again 1 ns after the next rising edge for the new value.
- **Pattern writes:** a write is checked twice, once before its edge (old contents) and once just after it (new contents).
- **Reset:** reset release passes through a two-stage synchronizer, so the bench waits three falling edges before its first write.

// File: rtl/pla_match_pkg.sv
package pla_match_pkg;

  // Reduction applied over the significant positions of one pattern
  typedef enum logic [1:0] {
    FN_AND  = 2'd0,
    FN_OR   = 2'd1,
    FN_NAND = 2'd2,
    FN_NOR  = 2'd3
  } comb_fn_e;

endpackage

// File: rtl/pla_rst_sync.sv
module pla_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/pla_pattern_store.sv
module pla_pattern_store #(
  parameter int PAT_W   = 8,
  parameter int NUM_PAT = 4,
  parameter int IDX_W   = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         wr_idx,
  input  logic [PAT_W-1:0]         wr_value,
  input  logic [PAT_W-1:0]         wr_care,
  output logic [NUM_PAT*PAT_W-1:0] value_flat,
  output logic [NUM_PAT*PAT_W-1:0] care_flat
);

  logic [NUM_PAT-1:0] row_we;

  for (genvar r = 0; r < NUM_PAT; r++) begin : g_row
    logic [PAT_W-1:0] val_q, care_q;
    logic [PAT_W-1:0] val_d, care_d;

    always_comb begin
      row_we[r] = wr_en && (wr_idx == IDX_W'(r));
      val_d     = wr_value;
      care_d    = wr_care;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val_q  <= '0;
        care_q <= '0;
      end else if (row_we[r]) begin
        val_q  <= val_d;
        care_q <= care_d;
      end
    end

    assign value_flat[r*PAT_W +: PAT_W] = val_q;
    assign care_flat[r*PAT_W +: PAT_W]  = care_q;
  end

endmodule

// File: rtl/pla_term_eval.sv
module pla_term_eval
  import pla_match_pkg::*;
#(
  parameter int PAT_W   = 8,
  parameter int NUM_PAT = 4
) (
  input  logic [PAT_W-1:0]         din,
  input  logic                     plane_mode,
  input  comb_fn_e                 fn,
  input  logic [NUM_PAT*PAT_W-1:0] value_flat,
  input  logic [NUM_PAT*PAT_W-1:0] care_flat,
  output logic [NUM_PAT-1:0]       term_vec
);

  for (genvar p = 0; p < NUM_PAT; p++) begin : g_term
    logic [PAT_W-1:0] val, care, sig, hit;
    logic             all_ok, any_ok, res;

    always_comb begin
      val  = value_flat[p*PAT_W +: PAT_W];
      care = care_flat[p*PAT_W +: PAT_W];
      // significant positions depend on the comparison style
      sig  = plane_mode ? care : (val & care);
      // array style: a significant stored one needs an input one
      hit  = plane_mode ? (~(din ^ val) & sig) : (din & sig);
      // empty pattern: all_ok = 1, any_ok = 0
      all_ok = &(hit | ~sig);
      any_ok = |hit;
      unique case (fn)
        FN_AND:  res = all_ok;
        FN_OR:   res = any_ok;
        FN_NAND: res = ~all_ok;
        FN_NOR:  res = ~any_ok;
        default: res = 1'b0;
      endcase
    end

    assign term_vec[p] = res;
  end

endmodule

// File: rtl/pla_out_stage.sv
module pla_out_stage #(
  parameter int NUM_PAT = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sync_sel,
  input  logic [NUM_PAT-1:0] term_vec,
  output logic [NUM_PAT-1:0] dout
);

  logic [NUM_PAT-1:0] out_q;
  logic [NUM_PAT-1:0] out_d;
  logic               out_en;

  always_comb begin
    out_en = 1'b1;
    out_d  = term_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
    end else if (out_en) begin
      out_q <= out_d;
    end
  end

  assign dout = sync_sel ? out_q : term_vec;

endmodule

// File: rtl/pla_match_array.sv
module pla_match_array
  import pla_match_pkg::*;
#(
  parameter int   PAT_W   = 8,
  parameter int   NUM_PAT = 4,
  parameter int   RST_STG = 2,
  localparam int  IDX_W   = (NUM_PAT > 1) ? $clog2(NUM_PAT) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_plane,
  input  logic [1:0]         cfg_func,
  input  logic               cfg_sync,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [PAT_W-1:0]   wr_value,
  input  logic [PAT_W-1:0]   wr_care,
  input  logic [PAT_W-1:0]   din,
  output logic [NUM_PAT-1:0] dout
);

  logic                     srst_n;
  logic [NUM_PAT*PAT_W-1:0] value_flat;
  logic [NUM_PAT*PAT_W-1:0] care_flat;
  logic [NUM_PAT-1:0]       term_vec;
  comb_fn_e                 fn_sel;

  assign fn_sel = comb_fn_e'(cfg_func);

  pla_rst_sync #(.STAGES(RST_STG)) rst_sync_i (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  pla_pattern_store #(.PAT_W(PAT_W), .NUM_PAT(NUM_PAT), .IDX_W(IDX_W)) store_i (
    .clk        (clk),
    .rst_n      (srst_n),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_value   (wr_value),
    .wr_care    (wr_care),
    .value_flat (value_flat),
    .care_flat  (care_flat)
  );

  pla_term_eval #(.PAT_W(PAT_W), .NUM_PAT(NUM_PAT)) eval_i (
    .din        (din),
    .plane_mode (cfg_plane),
    .fn         (fn_sel),
    .value_flat (value_flat),
    .care_flat  (care_flat),
    .term_vec   (term_vec)
  );

  pla_out_stage #(.NUM_PAT(NUM_PAT)) out_i (
    .clk      (clk),
    .rst_n    (srst_n),
    .sync_sel (cfg_sync),
    .term_vec (term_vec),
    .dout     (dout)
  );

endmodule

// File: rtl/pla_match_checker.sv
module pla_match_checker #(
  parameter int PAT_W   = 8,
  parameter int NUM_PAT = 4,
  parameter int IDX_W   = 2
) (
  input logic                     clk,
  input logic                     srst_n,
  input logic [1:0]               cfg_func,
  input logic                     cfg_sync,
  input logic                     wr_en,
  input logic [IDX_W-1:0]         wr_idx,
  input logic [PAT_W-1:0]         wr_value,
  input logic [PAT_W-1:0]         wr_care,
  input logic [NUM_PAT*PAT_W-1:0] value_flat,
  input logic [NUM_PAT*PAT_W-1:0] care_flat,
  input logic [NUM_PAT-1:0]       term_vec,
  input logic [NUM_PAT-1:0]       dout
);

  // one cycle after reset release, so $past sees out-of-reset values
  logic armed_q;
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (srst_n)
    cfg_sync |-> (dout == '0));

  assert_async_follow_R8: assert property (@(posedge clk) disable iff (!srst_n)
    !cfg_sync |-> (dout == term_vec));

  assert_sync_delay_R9: assert property (@(posedge clk) disable iff (!srst_n)
    (armed_q && cfg_sync) |-> (dout == $past(term_vec)));

  for (genvar i = 0; i < NUM_PAT; i++) begin : g_chk
    assert_write_store_R10: assert property (@(posedge clk) disable iff (!srst_n)
      (wr_en && wr_idx == IDX_W'(i)) |=>
        (value_flat[i*PAT_W +: PAT_W] == $past(wr_value)) &&
        (care_flat[i*PAT_W +: PAT_W] == $past(wr_care)));

    assert_write_other_R10: assert property (@(posedge clk) disable iff (!srst_n)
      !(wr_en && wr_idx == IDX_W'(i)) |=>
        $stable(value_flat[i*PAT_W +: PAT_W]) && $stable(care_flat[i*PAT_W +: PAT_W]));

    assert_empty_and_R7: assert property (@(posedge clk) disable iff (!srst_n)
      (!cfg_sync && care_flat[i*PAT_W +: PAT_W] == '0 && cfg_func == 2'd0) |-> dout[i]);

    assert_empty_or_R7: assert property (@(posedge clk) disable iff (!srst_n)
      (!cfg_sync && care_flat[i*PAT_W +: PAT_W] == '0 && cfg_func == 2'd1) |-> !dout[i]);
  end

endmodule

bind pla_match_array pla_match_checker #(
  .PAT_W   (PAT_W),
  .NUM_PAT (NUM_PAT),
  .IDX_W   (IDX_W)
) chk_i (
  .clk        (clk),
  .srst_n     (srst_n),
  .cfg_func   (cfg_func),
  .cfg_sync   (cfg_sync),
  .wr_en      (wr_en),
  .wr_idx     (wr_idx),
  .wr_value   (wr_value),
  .wr_care    (wr_care),
  .value_flat (value_flat),
  .care_flat  (care_flat),
  .term_vec   (term_vec),
  .dout       (dout)
);

// File: tb/pla_match_array_tb.sv
module pla_match_array_tb_top;

  localparam int W  = 8;
  localparam int NP = 4;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_plane;
  logic [1:0]    cfg_func;
  logic          cfg_sync;
  logic          wr_en;
  logic [IW-1:0] wr_idx;
  logic [W-1:0]  wr_value;
  logic [W-1:0]  wr_care;
  logic [W-1:0]  din;
  logic [NP-1:0] dout;

  int n_tests = 0;
  int n_fail  = 0;

  logic [W-1:0] sh_val  [NP];
  logic [W-1:0] sh_care [NP];

  always #5 clk = ~clk;

  pla_match_array #(.PAT_W(W), .NUM_PAT(NP)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_plane(cfg_plane), .cfg_func(cfg_func),
    .cfg_sync(cfg_sync), .wr_en(wr_en), .wr_idx(wr_idx), .wr_value(wr_value),
    .wr_care(wr_care), .din(din), .dout(dout)
  );

  // bit-counting model: count significant and matching positions
  function automatic logic [NP-1:0] model(input logic pl, input logic [1:0] fn,
                                          input logic [W-1:0] x);
    logic [NP-1:0] r;
    for (int p = 0; p < NP; p++) begin
      int nsig = 0;
      int nhit = 0;
      logic all_m, any_m;
      for (int b = 0; b < W; b++) begin
        if (sh_care[p][b] && (pl || sh_val[p][b])) begin
          nsig++;
          if (pl ? (x[b] == sh_val[p][b]) : x[b]) nhit++;
        end
      end
      all_m = (nhit == nsig);
      any_m = (nhit > 0);
      case (fn)
        2'd0:    r[p] = all_m;
        2'd1:    r[p] = any_m;
        2'd2:    r[p] = !all_m;
        default: r[p] = !any_m;
      endcase
    end
    return r;
  endfunction

  task automatic check(input logic ok, input string tag,
                       input logic [NP-1:0] act, input logic [NP-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: dout actual %b expected %b (din=%b plane=%0d func=%0d sync=%0d)",
               tag, act, exp, din, cfg_plane, cfg_func, cfg_sync);
    end
  endtask

  // write with before/after checks in combinational mode
  task automatic write_pat(input int idx, input logic [W-1:0] v, input logic [W-1:0] c);
    logic [NP-1:0] e;
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx[IW-1:0]; wr_value = v; wr_care = c;
    #1;
    e = model(cfg_plane, cfg_func, din);
    if (!cfg_sync) check(dout == e, "R10 old contents before edge", dout, e);
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    sh_val[idx] = v; sh_care[idx] = c;
    e = model(cfg_plane, cfg_func, din);
    if (!cfg_sync) check(dout == e, "R10 new contents after edge", dout, e);
  endtask

  task automatic sweep_async();
    logic [NP-1:0] e;
    cfg_sync = 1'b0;
    for (int pl = 0; pl < 2; pl++) begin
      for (int fn = 0; fn < 4; fn++) begin
        for (int v = 0; v < (1 << W); v++) begin
          cfg_plane = pl[0]; cfg_func = fn[1:0]; din = v[W-1:0];
          #1;
          e = model(cfg_plane, cfg_func, din);
          if (pl == 0 && fn == 0)      check(dout == e, "R2 R4 R8 array AND", dout, e);
          else if (pl == 0 && fn == 1) check(dout == e, "R2 R5 R8 array OR", dout, e);
          else if (pl == 0)            check(dout == e, "R2 R6 R8 array inverted", dout, e);
          else if (fn == 0)            check(dout == e, "R3 R4 R7 plane AND", dout, e);
          else if (fn == 1)            check(dout == e, "R3 R5 R7 plane OR", dout, e);
          else                         check(dout == e, "R3 R6 R7 plane inverted", dout, e);
        end
      end
    end
  endtask

  task automatic sweep_sync();
    logic [NP-1:0] cur, prev;
    @(negedge clk);
    cfg_sync = 1'b1; cfg_plane = 1'b0; cfg_func = 2'd0; din = '0;
    cur = model(1'b0, 2'd0, '0);
    @(posedge clk);
    for (int v = 0; v < (1 << W); v++) begin
      @(negedge clk);
      prev = cur;
      din = v[W-1:0] ^ 8'h5A; cfg_func = v[1:0]; cfg_plane = v[2];
      #1;
      check(dout == prev, "R9 hold between edges", dout, prev);
      cur = model(cfg_plane, cfg_func, din);
      @(posedge clk);
      #1;
      check(dout == cur, "R9 registered after edge", dout, cur);
    end
    @(negedge clk);
    cfg_sync = 1'b0;
  endtask

  task automatic probe(input logic pl, input logic [W-1:0] x,
                       input logic [2:0] exp012, input string tag);
    logic [2:0] got;
    cfg_sync = 1'b0; cfg_func = 2'd0; cfg_plane = pl; din = x;
    #1;
    got = {dout[0], dout[1], dout[2]};
    n_tests++;
    if (got != exp012) begin
      n_fail++;
      $display("FAIL %s: {dout0,dout1,dout2} actual %b expected %b (din=%b)", tag, got, exp012, x);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run incomplete, actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [NP-1:0] e;
    logic [31:0]   lcg;
    rst_n = 1'b0; cfg_plane = 1'b1; cfg_func = 2'd0; cfg_sync = 1'b1;
    wr_en = 1'b0; wr_idx = '0; wr_value = '0; wr_care = '0; din = 8'hA5;
    for (int p = 0; p < NP; p++) begin sh_val[p] = '0; sh_care[p] = '0; end
    repeat (2) @(posedge clk);
    #1;
    check(dout == '0, "R1 registered output in reset", dout, '0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // cleared contents: every pattern empty
    cfg_sync = 1'b0; cfg_plane = 1'b1; cfg_func = 2'd0; #1;
    check(dout == '1, "R1 R7 cleared patterns AND", dout, '1);
    cfg_func = 2'd1; #1;
    check(dout == '0, "R1 R7 cleared patterns OR", dout, '0);
    cfg_func = 2'd3; #1;
    check(dout == '1, "R1 R7 cleared patterns NOR", dout, '1);

    // example contents
    cfg_func = 2'd0; cfg_plane = 1'b0; din = 8'hFF;
    write_pat(0, 8'b11001100, 8'hFF);
    write_pat(1, 8'b00110011, 8'hFF);
    write_pat(2, 8'b00001111, 8'hFF);
    write_pat(3, 8'b00110000, 8'hF0);
    probe(1'b0, 8'b11001100, 3'b100, "R11 array AND");
    probe(1'b0, 8'b00001111, 3'b001, "R11 array AND");
    probe(1'b0, 8'b10101010, 3'b000, "R11 array AND");
    probe(1'b0, 8'b11000000, 3'b000, "R11 array AND");
    probe(1'b0, 8'b00111111, 3'b011, "R11 array AND");
    probe(1'b1, 8'b00111111, 3'b000, "R11 plane AND");
    foreach (sh_val[k]) begin end
    cfg_plane = 1'b1; cfg_func = 2'd0;
    din = 8'b00110101; #1;
    check(dout[3] == 1'b1, "R11 R3 don't-care match low nibble 0101", {3'b0, dout[3]}, 4'b0001);
    din = 8'b00111010; #1;
    check(dout[3] == 1'b1, "R11 R3 don't-care match low nibble 1010", {3'b0, dout[3]}, 4'b0001);
    din = 8'b01110000; #1;
    check(dout[3] == 1'b0, "R11 R3 top nibble mismatch", {3'b0, dout[3]}, 4'b0000);
    sweep_async();

    // pseudo-random contents, pattern 3 empty
    lcg = 32'h1234_5678;
    for (int s = 0; s < 3; s++) begin
      for (int p = 0; p < NP; p++) begin
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        if (p == NP - 1) write_pat(p, lcg[31:24], 8'h00);
        else             write_pat(p, lcg[31:24], lcg[23:16] | lcg[15:8]);
      end
      sweep_async();
    end

    // rewrite one pattern, others keep their results
    cfg_plane = 1'b1; cfg_func = 2'd0; din = 8'h3C;
    write_pat(1, 8'h3C, 8'hFF);
    e = model(1'b1, 2'd0, 8'h3C);
    check(dout == e && dout[1], "R10 rewritten pattern now matches", dout, e);

    sweep_sync();

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule